// File: doc/BRIEF.md
# Multi-Master Hardware Lock Bank

A bank of hardware mutual-exclusion flags shared by several bus masters, for example application cores and a companion controller that both need to guard a shared peripheral. Every lock owns one 32-bit register. A read of that register is the acquire operation. If the lock was free, the read returns 0 and the same access marks the lock taken. If it was already taken, the read returns 1 and the caller retries. Writing 0 to the register releases the lock. A single 32-bit status word reports the state of the lowest 32 locks.

Each master has its own simple synchronous request port: valid, write, byte address and write data. Its read data is registered and appears in the cycle after the request. All ports act on one shared set of lock flags. A fixed-priority rule settles same-cycle contention, and a release is applied before acquires in the same cycle. The number of locks is a parameter restricted to 32, 64, 128 or 256.

Top module: `hwlock_bank`

## Requirements
- R1: `NUM_LOCKS` is 32, 64, 128 or 256. Lock i is the word at byte address 0x100 + 4*i. Byte addresses at or beyond 0x100 + 4*NUM_LOCKS map to no lock.
- R2: A read of a free lock returns 0 and leaves that lock taken.
- R3: A read of a taken lock returns 1 and leaves the lock taken.
- R4: A write of data 0 to a lock register makes that lock free.
- R5: Read data for a request is valid in the cycle after it is presented. A request in the very next cycle already sees the updated lock state.
- R6: A read of the status word at byte address 0x000 returns bit i equal to the state of lock i (1 = taken) for i in 0..31, sampled before that cycle's updates. Locks 32 and above never appear in it.
- R7: When several ports read the same free lock in one cycle, the lowest-numbered port gets 0 and owns the lock. Every other such port gets 1.
- R8: When one port writes 0 to a taken lock while another reads it in the same cycle, the reader gets 0 and the lock ends taken.
- R9: A write of nonzero data to a lock register changes no lock. Any write to the status word changes no lock.
- R10: After reset every lock is free.
- R11: Reads of unmapped byte addresses (any word other than the status word and the lock range) return 0 and change no lock. Write accesses return 0 read data.
- R12: Lock read data has bits 31..1 equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PORTS | Per-port request strobe |
| req_write | input | NUM_PORTS | Per-port write (1) or read (0) |
| req_addr | input | NUM_PORTS*ADDR_W | Per-port byte address, port p at bits p*ADDR_W upward |
| req_wdata | input | NUM_PORTS*32 | Per-port write data |
| rsp_rdata | output | NUM_PORTS*32 | Per-port read data, registered one cycle |

## Verification
The hardest cases to reach from the ports are same-cycle collisions: several masters reading one free lock at once, and a release meeting an acquire on the same lock in the same cycle. The bench drives all three ports in a single cycle with chosen addresses. It does this both for all-reader contention and for a writer paired with a reader. It then confirms the final owner with a later read and a status read. Full sweeps over all 64 locks, with the issuing port rotating, check the address map and the status cut-off at lock 31.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

    localparam int DATA_W         = 32;
    localparam int LOCK_BASE_WORD = 'h40;   // byte offset 0x100
    localparam int STATUS_BITS    = 32;

    typedef logic [7:0] lock_idx_t;         // wide enough for 256 locks

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_LOCK   = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      is_write;
        logic      zero_data;
        lock_idx_t idx;
    } lock_req_t;

    function automatic bit legal_lock_count(input int n);
        return (n == 32) || (n == 64) || (n == 128) || (n == 256);
    endfunction

    function automatic logic is_lock_read(input lock_req_t r);
        return (r.kind == ACC_LOCK) && !r.is_write;
    endfunction

    function automatic logic is_lock_clear(input lock_req_t r);
        return (r.kind == ACC_LOCK) && r.is_write && r.zero_data;
    endfunction

endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode
    import hwlock_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LOCKS = 32
) (
    input  logic                valid_i,
    input  logic                write_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output lock_req_t           req_o
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] BASE_W = WORD_W'(LOCK_BASE_WORD);
    localparam logic [WORD_W-1:0] END_W  = WORD_W'(LOCK_BASE_WORD + NUM_LOCKS);

    logic [WORD_W-1:0] word;
    logic [1:0]        byte_lane;

    assign word      = addr_i[ADDR_W-1:2];
    assign byte_lane = addr_i[1:0];

    always_comb begin
        req_o           = '0;
        req_o.kind      = ACC_NONE;
        req_o.is_write  = write_i;
        req_o.zero_data = (wdata_i == '0);
        if (valid_i && (byte_lane == 2'b00)) begin
            if (word == '0) begin
                req_o.kind = ACC_STATUS;
            end else if ((word >= BASE_W) && (word < END_W)) begin
                req_o.kind = ACC_LOCK;
                req_o.idx  = lock_idx_t'(word - BASE_W);
            end
        end
    end

endmodule

// File: rtl/hwlock_arbiter.sv
module hwlock_arbiter
    import hwlock_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int NUM_LOCKS = 32
) (
    input  lock_req_t              req_i [NUM_PORTS],
    input  logic [NUM_LOCKS-1:0]   held_i,
    output logic [NUM_LOCKS-1:0]   clear_o,
    output logic [NUM_LOCKS-1:0]   set_o,
    output logic [NUM_PORTS-1:0]   grant_o
);
    logic taken;
    logic beaten;

    // releases first: any port clearing lock l frees it for this cycle's readers
    always_comb begin
        clear_o = '0;
        for (int l = 0; l < NUM_LOCKS; l++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (is_lock_clear(req_i[p]) && (req_i[p].idx == lock_idx_t'(l)))
                    clear_o[l] = 1'b1;
            end
        end
    end

    // fixed priority: a reader loses to any lower-numbered reader of the same lock
    always_comb begin
        grant_o = '0;
        set_o   = '0;
        taken   = 1'b0;
        beaten  = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            taken  = 1'b0;
            beaten = 1'b0;
            for (int l = 0; l < NUM_LOCKS; l++) begin
                if (req_i[p].idx == lock_idx_t'(l))
                    taken = held_i[l] & ~clear_o[l];
            end
            for (int q = 0; q < p; q++) begin
                if (is_lock_read(req_i[q]) && (req_i[q].idx == req_i[p].idx))
                    beaten = 1'b1;
            end
            if (is_lock_read(req_i[p]) && !taken && !beaten) begin
                grant_o[p] = 1'b1;
                for (int l = 0; l < NUM_LOCKS; l++) begin
                    if (req_i[p].idx == lock_idx_t'(l))
                        set_o[l] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/hwlock_state.sv
module hwlock_state #(
    parameter int NUM_LOCKS = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LOCKS-1:0]  clear_i,
    input  logic [NUM_LOCKS-1:0]  set_i,
    output logic [NUM_LOCKS-1:0]  held_o
);
    always_ff @(posedge clk) begin
        if (rst)
            held_o <= '0;
        else
            held_o <= (held_o & ~clear_i) | set_i;
    end
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
    import hwlock_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int NUM_LOCKS = 64,
    parameter int ADDR_W    = 12
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PORTS-1:0]           req_valid,
    input  logic [NUM_PORTS-1:0]           req_write,
    input  logic [NUM_PORTS*ADDR_W-1:0]    req_addr,
    input  logic [NUM_PORTS*DATA_W-1:0]    req_wdata,
    output logic [NUM_PORTS*DATA_W-1:0]    rsp_rdata
);
    generate
        if (!legal_lock_count(NUM_LOCKS)) begin : g_bad_count
            $error("hwlock_bank: NUM_LOCKS must be 32, 64, 128 or 256");
        end
    endgenerate

    lock_req_t                dec [NUM_PORTS];
    logic [NUM_LOCKS-1:0]     held;
    logic [NUM_LOCKS-1:0]     clear_v;
    logic [NUM_LOCKS-1:0]     set_v;
    logic [NUM_PORTS-1:0]     grant;
    logic [NUM_PORTS*DATA_W-1:0] rdata_q;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        hwlock_decode #(
            .ADDR_W   (ADDR_W),
            .NUM_LOCKS(NUM_LOCKS)
        ) u_dec (
            .valid_i (req_valid[g]),
            .write_i (req_write[g]),
            .addr_i  (req_addr[g*ADDR_W +: ADDR_W]),
            .wdata_i (req_wdata[g*DATA_W +: DATA_W]),
            .req_o   (dec[g])
        );
    end

    hwlock_arbiter #(
        .NUM_PORTS(NUM_PORTS),
        .NUM_LOCKS(NUM_LOCKS)
    ) u_arb (
        .req_i   (dec),
        .held_i  (held),
        .clear_o (clear_v),
        .set_o   (set_v),
        .grant_o (grant)
    );

    hwlock_state #(
        .NUM_LOCKS(NUM_LOCKS)
    ) u_state (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear_v),
        .set_i   (set_v),
        .held_o  (held)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                rdata_q[p*DATA_W +: DATA_W] <= '0;
                if (!dec[p].is_write) begin
                    case (dec[p].kind)
                        ACC_STATUS: rdata_q[p*DATA_W +: DATA_W] <= held[STATUS_BITS-1:0];
                        ACC_LOCK:   rdata_q[p*DATA_W +: DATA_W] <= {{(DATA_W-1){1'b0}}, ~grant[p]};
                        default:    rdata_q[p*DATA_W +: DATA_W] <= '0;
                    endcase
                end
            end
        end
    end

    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/hwlock_bank_chk.sv
module hwlock_bank_chk
    import hwlock_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int NUM_LOCKS = 64,
    parameter int ADDR_W    = 12
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PORTS-1:0]           req_valid,
    input  logic [NUM_PORTS-1:0]           req_write,
    input  logic [NUM_PORTS*ADDR_W-1:0]    req_addr,
    input  logic [NUM_PORTS*DATA_W-1:0]    req_wdata,
    input  logic [NUM_PORTS*DATA_W-1:0]    rsp_rdata,
    input  logic [NUM_LOCKS-1:0]           held
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] BASE_W = WORD_W'(LOCK_BASE_WORD);
    localparam logic [WORD_W-1:0] END_W  = WORD_W'(LOCK_BASE_WORD + NUM_LOCKS);

    logic [WORD_W-1:0] word0;
    logic              p0_in_range;
    logic              p0_lrd;
    logic              p0_lclr;
    lock_idx_t         idx0;
    lock_idx_t         idx0_q;
    logic              p0_held;
    logic              prev_held;
    logic              other_clr;
    logic              other_rd;
    logic              p1_same_rd;

    assign word0       = req_addr[ADDR_W-1:2];
    assign p0_in_range = (req_addr[1:0] == 2'b00) && (word0 >= BASE_W) && (word0 < END_W);
    assign idx0        = lock_idx_t'(word0 - BASE_W);
    assign p0_lrd      = req_valid[0] && !req_write[0] && p0_in_range;
    assign p0_lclr     = req_valid[0] && req_write[0] && p0_in_range && (req_wdata[DATA_W-1:0] == '0);

    always_ff @(posedge clk) idx0_q <= idx0;

    always_comb begin
        p0_held   = 1'b0;
        prev_held = 1'b0;
        for (int l = 0; l < NUM_LOCKS; l++) begin
            if (idx0 == lock_idx_t'(l))   p0_held   = held[l];
            if (idx0_q == lock_idx_t'(l)) prev_held = held[l];
        end
    end

    always_comb begin
        other_clr  = 1'b0;
        other_rd   = 1'b0;
        p1_same_rd = 1'b0;
        for (int p = 1; p < NUM_PORTS; p++) begin
            if (req_valid[p] && (req_addr[p*ADDR_W +: ADDR_W] == req_addr[ADDR_W-1:0])) begin
                if (req_write[p] && (req_wdata[p*DATA_W +: DATA_W] == '0)) other_clr = 1'b1;
                if (!req_write[p]) other_rd = 1'b1;
                if (!req_write[p] && (p == 1)) p1_same_rd = 1'b1;
            end
        end
    end

    AST_RESET_FREE: assert property (@(posedge clk) rst |=> (held == '0));                         // R10

    AST_FREE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (p0_lrd && !p0_held) |=> (rsp_rdata[DATA_W-1:0] == '0) && prev_held);                     // R2

    AST_TAKEN_READ_ONE: assert property (@(posedge clk) disable iff (rst)
        (p0_lrd && p0_held && !other_clr) |=> (rsp_rdata[DATA_W-1:0] == 32'd1) && prev_held);     // R3

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (p0_lclr && !other_rd) |=> !prev_held);                                                   // R4

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        p0_lrd |=> (rsp_rdata[DATA_W-1:1] == '0));                                                // R12

    generate
        if (NUM_PORTS > 1) begin : g_pair
            AST_LOSER_GETS_ONE: assert property (@(posedge clk) disable iff (rst)
                (p0_lrd && p1_same_rd) |=> (rsp_rdata[2*DATA_W-1:DATA_W] == 32'd1));              // R7
        end
    endgenerate

endmodule

bind hwlock_bank hwlock_bank_chk #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_LOCKS(NUM_LOCKS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .held      (held)
);

// File: tb/tb_hwlock_bank.sv
`timescale 1ns/1ps
module tb_hwlock_bank;
    localparam int NP = 3;
    localparam int NL = 64;
    localparam int AW = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP-1:0]     req_valid;
    logic [NP-1:0]     req_write;
    logic [NP*AW-1:0]  req_addr;
    logic [NP*32-1:0]  req_wdata;
    logic [NP*32-1:0]  rsp_rdata;

    logic        v  [NP];
    logic        wr [NP];
    logic [11:0] ad [NP];
    logic [31:0] wd [NP];

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            req_valid[p]           = v[p];
            req_write[p]           = wr[p];
            req_addr[p*AW +: AW]   = ad[p];
            req_wdata[p*32 +: 32]  = wd[p];
        end
    end

    hwlock_bank #(.NUM_PORTS(NP), .NUM_LOCKS(NL), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [11:0] lock_addr(input int i);
        return 12'(32'h100 + 4 * i);
    endfunction

    task automatic idle();
        for (int p = 0; p < NP; p++) begin
            v[p] = 1'b0; wr[p] = 1'b0; ad[p] = '0; wd[p] = '0;
        end
    endtask

    task automatic set_op(input int p, input bit w, input logic [11:0] a, input logic [31:0] d);
        v[p] = 1'b1; wr[p] = w; ad[p] = a; wd[p] = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input int p, input logic [31:0] exp, input string tag);
        logic [31:0] act;
        act = rsp_rdata[p*32 +: 32];
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s port %0d: actual %h expected %h", tag, p, act, exp);
        end
    endtask

    // one single-port access, result checked one cycle later
    task automatic access(input int p, input bit w, input logic [11:0] a,
                          input logic [31:0] d, input logic [31:0] exp, input string tag);
        idle();
        set_op(p, w, a, d);
        step();
        chk(p, exp, tag);
        idle();
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state, everything free
        access(0, 0, 12'h000, 0, 32'h0, "R10 status after reset");

        // R2, R1: sweep acquire of every lock, rotating ports
        for (int i = 0; i < NL; i++) access(i % NP, 0, lock_addr(i), 0, 32'h0, "R2 R1 acquire free");
        // R3: second sweep finds all taken
        for (int i = 0; i < NL; i++) access((i + 1) % NP, 0, lock_addr(i), 0, 32'h1, "R3 R12 read taken");
        access(1, 0, 12'h000, 0, 32'hFFFF_FFFF, "R6 status all low locks held");

        // R6: releasing high locks leaves status untouched
        for (int i = 32; i < NL; i++) access(i % NP, 1, lock_addr(i), 0, 32'h0, "R11 write returns zero");
        access(2, 0, 12'h000, 0, 32'hFFFF_FFFF, "R6 high locks not in status");
        access(0, 0, lock_addr(40), 0, 32'h0, "R4 released high lock reacquired");
        access(0, 1, lock_addr(40), 0, 32'h0, "R4 release lock 40");
        for (int i = 0; i < 32; i++) access(i % NP, 1, lock_addr(i), 0, 32'h0, "R4 release");
        access(0, 0, 12'h000, 0, 32'h0, "R4 status after full release");

        // R1: lock 0 maps to 0x100, first word past the range maps to nothing
        access(0, 0, 12'h100, 0, 32'h0, "R1 lock 0 acquire");
        access(1, 0, 12'h000, 0, 32'h1, "R1 lock 0 in status bit 0");
        access(2, 0, lock_addr(NL), 0, 32'h0, "R1 beyond range reads zero");
        access(0, 0, lock_addr(NL - 1), 0, 32'h0, "R1 last lock acquire");
        access(0, 0, lock_addr(NL - 1), 0, 32'h1, "R1 last lock now taken");
        access(0, 1, lock_addr(NL - 1), 0, 32'h0, "R4 release last lock");
        access(1, 0, 12'h000, 0, 32'h1, "R11 status unchanged");
        access(0, 1, 12'h100, 0, 32'h0, "R4 release lock 0");

        // R5: back-to-back requests see the new state
        idle(); set_op(0, 0, lock_addr(9), 0); step(); chk(0, 32'h0, "R5 first acquire");
        idle(); set_op(1, 0, lock_addr(9), 0); step(); chk(1, 32'h1, "R5 next cycle sees taken");
        idle(); set_op(2, 1, lock_addr(9), 0); step(); chk(2, 32'h0, "R5 release write");
        idle(); set_op(0, 0, lock_addr(9), 0); step(); chk(0, 32'h0, "R5 next cycle sees free");
        access(0, 1, lock_addr(9), 0, 32'h0, "R4 release lock 9");

        // R7: contention on a free lock
        idle();
        set_op(0, 0, lock_addr(5), 0); set_op(1, 0, lock_addr(5), 0); set_op(2, 0, lock_addr(5), 0);
        step();
        chk(0, 32'h0, "R7 port 0 wins");
        chk(1, 32'h1, "R7 port 1 loses");
        chk(2, 32'h1, "R7 port 2 loses");
        idle();
        set_op(1, 0, lock_addr(6), 0); set_op(2, 0, lock_addr(6), 0);
        step();
        chk(1, 32'h0, "R7 port 1 wins over 2");
        chk(2, 32'h1, "R7 port 2 loses to 1");
        idle();
        access(0, 0, 12'h000, 0, 32'h0000_0060, "R7 single owner per lock");

        // R8: release and acquire collide
        access(0, 0, lock_addr(7), 0, 32'h0, "R8 setup acquire 7");
        idle();
        set_op(2, 1, lock_addr(7), 0); set_op(1, 0, lock_addr(7), 0);
        step();
        chk(1, 32'h0, "R8 reader sees release first");
        chk(2, 32'h0, "R8 writer data zero");
        idle();
        access(0, 0, lock_addr(7), 0, 32'h1, "R8 lock ends taken");
        access(0, 0, 12'h000, 0, 32'h0000_00E0, "R8 status");

        // R9: nonzero writes and status writes do nothing
        access(0, 1, lock_addr(5), 32'h1, 32'h0, "R9 nonzero write");
        access(1, 0, lock_addr(5), 0, 32'h1, "R9 lock 5 still taken");
        access(2, 1, lock_addr(4), 32'hFFFF_FFFF, 32'h0, "R9 nonzero write free lock");
        access(2, 0, lock_addr(4), 0, 32'h0, "R9 lock 4 stayed free");
        access(0, 1, 12'h000, 32'h0, 32'h0, "R9 status write");
        access(1, 0, 12'h000, 0, 32'h0000_00F0, "R9 status after writes");

        // R11: unmapped addresses
        access(0, 0, 12'h004, 0, 32'h0, "R11 word 1");
        access(1, 0, 12'h0FC, 0, 32'h0, "R11 below lock range");
        access(2, 0, 12'h200, 0, 32'h0, "R11 above lock range");
        access(0, 0, 12'hFFC, 0, 32'h0, "R11 top word");
        access(0, 1, 12'h0FC, 0, 32'h0, "R11 unmapped write");
        access(1, 0, 12'h000, 0, 32'h0000_00F0, "R11 no side effect");

        // R6: status sampled before same-cycle acquire
        idle();
        set_op(0, 0, 12'h000, 0); set_op(1, 0, lock_addr(2), 0);
        step();
        chk(0, 32'h0000_00F0, "R6 status shows prior state");
        chk(1, 32'h0, "R6 R2 acquire lock 2");
        idle();
        access(0, 0, 12'h000, 0, 32'h0000_00F4, "R6 status updated");
        access(2, 0, lock_addr(40), 0, 32'h0, "R6 acquire lock 40");
        access(0, 0, 12'h000, 0, 32'h0000_00F4, "R6 lock 40 not in status");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule